// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a CPU-controlled asynchronous transmitter and receiver. A CPU reaches it through one address bit that picks the data port or the control port, plus write and read strobes. Writes to the control port go through two phases: right after reset, the first control write sets the line format (mode). Every control write after that is a command. A command with its internal-reset bit set returns the port to the mode phase. Reading the control port returns a status byte. The block drives the serial output, RTS and DTR. It takes the serial input and an active-low data-set-ready input.

Bit timing comes from `baud_tick`, which pulses once per period of the external serial clock. A mode field sets how many ticks make one bit cell: 1, 16 or 64. The transmit data port is a holding register, and status bit 0 is its ready flag. A data write made while that flag is low replaces the held byte, so the CPU must honour the flag. On the receive side, status bit 1 is the valid flag. The receiver has no back-pressure: a character that completes while the previous one is unread is still stored, and an overrun is flagged.

Top module: `serial_port_core`

## Requirements
- R1: After reset, or after a command whose bit 6 is 1, the next control write is the mode byte and does not change RTS, DTR or the enables. A bit-6 command also clears every command bit. All other control writes are commands, and command bit 7 is ignored.
- R2: Mode byte fields: [7:6] stop length (01 = 1, 10 = 1.5, 11 = 2). [5] parity enable. [4] 1 = even, 0 = odd. [3:2] character length 5 + value. [1:0] ticks per bit (01 = 1, 10 = 16, 11 = 64). The reset mode is 0x4E.
- R3: A transmitted frame is a low start cell, then the data bits LSB first, then the parity bit if enabled, then high stop cells. Data bits above the character length are dropped. Even parity makes the total count of ones over data and parity even.
- R4: Command bit 5 drives `rts` high, bit 1 drives `dtr` high, and bit 3 forces `txd` low.
- R5: Status byte: [0] command bit 0 set and holding register empty; [1] received character waiting; [2] holding register empty and shifter idle; [3] parity error; [4] overrun; [5] framing error; [6] break; [7] inverse of `dsr_n`.
- R6: At 16 and 64 ticks per bit, a start bit is accepted only if the input is still low half a cell after the falling edge. A low pulse shorter than that is ignored. Received characters are right-aligned, and the unused upper bits read as zero.
- R7: The parity error flag is set when the received parity bit does not match the selected parity over the data bits.
- R8: The waiting flag is set when a character completes and cleared by a data-port read. If both happen in the same cycle, the flag stays set.
- R9: If a character completes while the waiting flag is set and no read happens in that cycle, the overrun flag is set and the new character replaces the old one.
- R10: The framing error flag is set when the first stop bit is sampled low.
- R11: A command with bit 4 set (and bit 6 clear) clears the parity, overrun and framing flags.
- R12: The break flag is set after the serial input has been low for a whole character time, including the stop bits, with the receiver enabled. It clears as soon as the input goes high.
- R13: While command bit 2 is 0, the receiver ignores the line and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per external serial clock period |
| sel_ctl | input | 1 | 1 selects the control/status port, 0 the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (a data read consumes the character) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status byte or received character, selected by sel_ctl |
| txd | output | 1 | Serial output, idle high |
| rts | output | 1 | Request-to-send, active high |
| dtr | output | 1 | Data-terminal-ready, active high |
| rxd | input | 1 | Serial input, idle high |
| dsr_n | input | 1 | Data-set-ready, active low |

## Verification
A CPU read of the data port and the completion of the next character can land on the same clock edge. This is where the waiting flag's set and clear meet, and where the overrun condition is decided. The bench provokes it by leaving one character unread. It then drives a second frame while counting edges from the start bit, so that the read strobe sits exactly on the stop-bit sample edge. The result is correct if that read returns the old character, the waiting flag is still set, no overrun is flagged, and the following read returns the new character.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DW     = 8;
  localparam int CNT_W  = 8;
  localparam int BRK_W  = 10;
  localparam int IDX_W  = 4;

  typedef struct packed {
    logic [1:0] stop;
    logic       par_en;
    logic       par_even;
    logic [1:0] len;
    logic [1:0] fac;
  } sp_mode_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} sp_state_t;

  function automatic logic [CNT_W-1:0] cell_ticks(input logic [1:0] fac);
    case (fac)
      2'b10:   return CNT_W'(16);
      2'b11:   return CNT_W'(64);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stop_ticks(input sp_mode_t m);
    logic [CNT_W-1:0] ft;
    ft = cell_ticks(m.fac);
    case (m.stop)
      2'b10:   return ft + ((ft + CNT_W'(1)) >> 1);
      2'b11:   return ft << 1;
      default: return ft;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] char_bits(input sp_mode_t m);
    return IDX_W'(5) + {2'b00, m.len};
  endfunction

  function automatic logic [DW-1:0] char_mask(input sp_mode_t m);
    return 8'hFF >> (IDX_W'(8) - char_bits(m));
  endfunction
endpackage

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  sp_mode_t      mode,
  input  logic          tx_en,
  input  logic          brk,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          txd,
  output logic          hold_empty,
  output logic          idle
);
  sp_state_t        st;
  logic [DW-1:0]    hold_q, sh;
  logic             hold_full, line, par_q, load;
  logic [CNT_W-1:0] cnt, dur;
  logic [IDX_W-1:0] bidx, nlen;
  logic [DW-1:0]    masked;

  always_comb begin
    nlen   = char_bits(mode);
    masked = hold_q & char_mask(mode);
    dur    = (st == S_STOP) ? stop_ticks(mode) : cell_ticks(mode.fac);
    load   = tick && (st == S_IDLE) && tx_en && hold_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hold_q <= '0; sh <= '0; hold_full <= 1'b0;
      line <= 1'b1; par_q <= 1'b0; cnt <= '0; bidx <= '0;
    end else begin
      if (wr) hold_q <= wdata;
      hold_full <= wr | (hold_full & ~load);
      if (tick) begin
        if (st == S_IDLE) begin
          if (load) begin
            sh    <= masked;
            par_q <= mode.par_even ? ^masked : ~^masked;
            line  <= 1'b0;
            st    <= S_START;
            cnt   <= '0;
          end
        end else if (cnt == dur - CNT_W'(1)) begin
          cnt <= '0;
          case (st)
            S_START: begin line <= sh[0]; bidx <= '0; st <= S_DATA; end
            S_DATA: begin
              if (bidx == nlen - IDX_W'(1)) begin
                if (mode.par_en) begin line <= par_q; st <= S_PAR; end
                else begin line <= 1'b1; st <= S_STOP; end
              end else begin
                sh   <= {1'b0, sh[DW-1:1]};
                line <= sh[1];
                bidx <= bidx + IDX_W'(1);
              end
            end
            S_PAR:   begin line <= 1'b1; st <= S_STOP; end
            default: st <= S_IDLE;
          endcase
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign txd        = brk ? 1'b0 : line;
  assign hold_empty = ~hold_full;
  assign idle       = (st == S_IDLE);
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  sp_mode_t      mode,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic          rd,
  input  logic          err_clr,
  output logic [DW-1:0] rx_byte,
  output logic          ready,
  output logic          pe,
  output logic          oe,
  output logic          fe,
  output logic          brk_det,
  output logic          done
);
  sp_state_t        st;
  logic [DW-1:0]    sh;
  logic [CNT_W-1:0] cnt, ft, half;
  logic [IDX_W-1:0] bidx, nlen, nframe;
  logic             par_acc, par_bit, par_bad;
  logic [BRK_W-1:0] lowcnt, thresh;

  always_comb begin
    ft      = cell_ticks(mode.fac);
    half    = ft >> 1;
    nlen    = char_bits(mode);
    nframe  = IDX_W'(1) + nlen + IDX_W'(mode.par_en) + (mode.stop[1] ? IDX_W'(2) : IDX_W'(1));
    thresh  = BRK_W'(ft) * BRK_W'(nframe);
    done    = rx_en && tick && (st == S_STOP) && (cnt == ft - CNT_W'(1));
    par_bad = mode.par_en && (par_bit != (mode.par_even ? par_acc : ~par_acc));
    brk_det = !rxd && (lowcnt == thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; bidx <= '0;
      par_acc <= 1'b0; par_bit <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE; cnt <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (!rxd) begin
          par_acc <= 1'b0; bidx <= '0;
          if (ft == CNT_W'(1)) begin st <= S_DATA; cnt <= '0; end
          else begin st <= S_START; cnt <= CNT_W'(1); end
        end
        S_START: if (cnt == half) begin
          st  <= rxd ? S_IDLE : S_DATA;
          cnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        default: if (cnt == ft - CNT_W'(1)) begin
          cnt <= '0;
          case (st)
            S_DATA: begin
              sh      <= {rxd, sh[DW-1:1]};
              par_acc <= par_acc ^ rxd;
              if (bidx == nlen - IDX_W'(1)) st <= mode.par_en ? S_PAR : S_STOP;
              else bidx <= bidx + IDX_W'(1);
            end
            S_PAR:   begin par_bit <= rxd; st <= S_STOP; end
            default: st <= S_IDLE;
          endcase
        end else cnt <= cnt + CNT_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0; ready <= 1'b0; pe <= 1'b0; oe <= 1'b0; fe <= 1'b0; lowcnt <= '0;
    end else begin
      ready <= done | (ready & ~rd);
      if (done) rx_byte <= sh >> (IDX_W'(8) - nlen);
      pe <= (pe & ~err_clr) | (done & par_bad);
      oe <= (oe & ~err_clr) | (done & ready & ~rd);
      fe <= (fe & ~err_clr) | (done & ~rxd);
      if (rxd || !rx_en) lowcnt <= '0;
      else if (tick && lowcnt != thresh) lowcnt <= lowcnt + BRK_W'(1);
    end
  end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import sp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          sel_ctl,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          txd,
  output logic          rts,
  output logic          dtr,
  input  logic          rxd,
  input  logic          dsr_n
);
  sp_mode_t      mode_q;
  logic          phase_mode, rts_q, dtr_q, brk_q, rxen_q, txen_q;
  logic          ctl_wr, data_wr, data_rd, err_clr;
  logic          hold_empty, tx_idle;
  logic [DW-1:0] rx_byte, stat;
  logic          ready, pe, oe, fe, brk_det, rx_done;

  assign ctl_wr  = wr_en & sel_ctl;
  assign data_wr = wr_en & ~sel_ctl;
  assign data_rd = rd_en & ~sel_ctl;
  assign err_clr = ctl_wr & ~phase_mode & wdata[4] & ~wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= sp_mode_t'(8'h4E); phase_mode <= 1'b1;
      {rts_q, dtr_q, brk_q, rxen_q, txen_q} <= '0;
    end else if (ctl_wr) begin
      if (phase_mode) begin
        mode_q     <= sp_mode_t'(wdata);
        phase_mode <= 1'b0;
      end else if (wdata[6]) begin
        phase_mode <= 1'b1;
        {rts_q, dtr_q, brk_q, rxen_q, txen_q} <= '0;
      end else begin
        rts_q  <= wdata[5];
        brk_q  <= wdata[3];
        rxen_q <= wdata[2];
        dtr_q  <= wdata[1];
        txen_q <= wdata[0];
      end
    end
  end

  sp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode_q),
    .tx_en(txen_q), .brk(brk_q), .wr(data_wr), .wdata(wdata),
    .txd(txd), .hold_empty(hold_empty), .idle(tx_idle)
  );

  sp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode_q),
    .rx_en(rxen_q), .rxd(rxd), .rd(data_rd), .err_clr(err_clr),
    .rx_byte(rx_byte), .ready(ready), .pe(pe), .oe(oe), .fe(fe),
    .brk_det(brk_det), .done(rx_done)
  );

  assign stat  = {~dsr_n, brk_det, fe, oe, pe, hold_empty & tx_idle, ready, txen_q & hold_empty};
  assign rdata = sel_ctl ? stat : rx_byte;
  assign rts   = rts_q;
  assign dtr   = dtr_q;
endmodule

// File: rtl/sp_chk.sv
module sp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_ctl,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] stat,
  input logic       txd,
  input logic       rts,
  input logic       dtr,
  input logic       rxd,
  input logic       phase_mode,
  input logic       rx_done
);
  logic cw, cmd_w, rd_d;
  assign cw    = wr_en && sel_ctl;
  assign cmd_w = cw && !phase_mode && !wdata[6];
  assign rd_d  = rd_en && !sel_ctl;

  a_r1_mode_keeps_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && phase_mode) |=> ($stable(rts) && $stable(dtr)));
  a_r1_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && !phase_mode && wdata[6]) |=> (!rts && !dtr && phase_mode));
  a_r4_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wdata[3]) |=> !txd);
  a_r5_txrdy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ctl) |=> !stat[0]);
  a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> stat[1]);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_d && !rx_done) |=> !stat[1]);
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && stat[1] && !rd_d) |=> stat[4]);
  a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wdata[4] && !rx_done) |=> (stat[5:3] == 3'b000));
  a_r12_break_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rxd |=> !stat[6]);
endmodule

bind serial_port_core sp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_ctl(sel_ctl), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .stat(stat), .txd(txd), .rts(rts), .dtr(dtr), .rxd(rxd),
  .phase_mode(phase_mode), .rx_done(rx_done)
);

// File: tb/serial_port_core_tb.sv
module serial_port_core_tb;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1;
  logic sel_ctl = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic txd, rts, dtr, rxd_drv = 1'b1, loop = 1'b0, dsr_n = 1'b1, rxd;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  assign rxd = loop ? txd : rxd_drv;
  always #2.5 clk = ~clk;

  serial_port_core u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .sel_ctl(sel_ctl),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .txd(txd), .rts(rts), .dtr(dtr), .rxd(rxd), .dsr_n(dsr_n)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); sel_ctl = 1'b1; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] v);
    @(negedge clk); sel_ctl = 1'b0; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic get_status(output logic [7:0] s);
    @(negedge clk); sel_ctl = 1'b1; #1 s = rdata;
  endtask

  task automatic read_data(output logic [7:0] d);
    @(negedge clk); sel_ctl = 1'b0; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_format(input logic [7:0] m);
    ctl_write(8'h40); ctl_write(m); ctl_write(8'h37);
  endtask

  task automatic drain();
    logic [7:0] d;
    repeat (20) @(negedge clk);
    read_data(d); ctl_write(8'h37);
  endtask

  task automatic rx_send(input logic [7:0] d, input int nb, input bit pen, input bit peven,
                         input bit flip, input bit stopv, input int f);
    logic p;
    p = peven ? ^(d & (8'hFF >> (8 - nb))) : ~^(d & (8'hFF >> (8 - nb)));
    @(negedge clk); rxd_drv = 1'b0;
    repeat (f) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd_drv = d[i]; repeat (f) @(negedge clk); end
    if (pen) begin rxd_drv = p ^ flip; repeat (f) @(negedge clk); end
    rxd_drv = stopv; repeat (f) @(negedge clk);
    rxd_drv = 1'b1; repeat (f) @(negedge clk);
  endtask

  task automatic tx_capture(input int nb, input bit pen, input int f,
                            output logic [7:0] d, output logic p, output logic stp);
    d = '0; p = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (f / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin repeat (f) @(negedge clk); d[i] = txd; end
    if (pen) begin repeat (f) @(negedge clk); p = txd; end
    repeat (f) @(negedge clk); stp = txd;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    get_status(s);
    chk(s == 8'h04, "R5 reset status", s, 8'h04);
    chk(txd && !rts && !dtr, "R4 reset lines", {5'b0, txd, rts, dtr}, 8'h04);
  endtask

  task automatic t_phase();
    ctl_write(8'h4E); ctl_write(8'h37);
    chk(rts && dtr, "R1 command after mode", {6'b0, rts, dtr}, 8'h03);
    ctl_write(8'h40);
    chk(!rts && !dtr, "R1 internal reset clears command", {6'b0, rts, dtr}, 8'h00);
    ctl_write(8'h22);
    chk(!rts && !dtr, "R1 write after reset is mode", {6'b0, rts, dtr}, 8'h00);
    ctl_write(8'h40); ctl_write(8'h4E); ctl_write(8'h22);
    chk(rts && dtr, "R4 rts dtr driven", {6'b0, rts, dtr}, 8'h03);
    ctl_write(8'hB7);
    chk(rts && dtr, "R1 hunt bit ignored", {6'b0, rts, dtr}, 8'h03);
  endtask

  task automatic t_tx_8n1();
    logic [7:0] s, d; logic p, stp;
    set_format(8'h4E);
    get_status(s);
    chk(s[0] == 1'b1, "R5 transmit free", s, 8'h05);
    data_write(8'hA5); data_write(8'h3C);
    get_status(s);
    chk(s[0] == 1'b0 && s[2] == 1'b0, "R5 holding full", s, 8'h00);
    tx_capture(8, 0, 16, d, p, stp);
    chk(d == 8'hA5 && stp, "R3 frame 8N1 first", d, 8'hA5);
    tx_capture(8, 0, 16, d, p, stp);
    chk(d == 8'h3C && stp, "R3 frame 8N1 second", d, 8'h3C);
    repeat (20) @(negedge clk);
    get_status(s);
    chk(s[2] == 1'b1, "R5 transmitter idle", s, 8'h05);
  endtask

  task automatic t_tx_7e1();
    logic [7:0] d; logic p, stp;
    set_format(8'h7A);
    data_write(8'h41);
    tx_capture(7, 1, 16, d, p, stp);
    chk(d == 8'h41 && p == 1'b0, "R3 even parity two ones", {d[6:0], p}, 8'h82);
    data_write(8'h43);
    tx_capture(7, 1, 16, d, p, stp);
    chk(d == 8'h43 && p == 1'b1, "R3 even parity three ones", {d[6:0], p}, 8'h87);
  endtask

  task automatic t_loop(input logic [7:0] m, input logic [7:0] v, input logic [7:0] exp, input int wait_cyc, input string req);
    logic [7:0] d, s;
    set_format(m); loop = 1'b1;
    drain();
    data_write(v);
    repeat (wait_cyc) @(negedge clk);
    get_status(s);
    chk(s[1] && s[5:3] == 3'b000, req, s, 8'h07);
    read_data(d);
    chk(d == exp, req, d, exp);
    loop = 1'b0;
  endtask

  task automatic t_glitch();
    logic [7:0] s;
    set_format(8'h4E); drain();
    @(negedge clk); rxd_drv = 1'b0; repeat (4) @(negedge clk); rxd_drv = 1'b1;
    repeat (200) @(negedge clk);
    get_status(s);
    chk(s[1] == 1'b0, "R6 short low pulse rejected", s, 8'h05);
  endtask

  task automatic t_parity();
    logic [7:0] s, d;
    set_format(8'h7A); drain();
    rx_send(8'h55, 7, 1, 1, 1, 1, 16);
    get_status(s);
    chk(s[3] && s[1], "R7 parity error flagged", s, 8'h0F);
    read_data(d);
    chk(d == 8'h55, "R7 data with parity error", d, 8'h55);
    ctl_write(8'h37);
    get_status(s);
    chk(s[5:3] == 3'b000, "R11 error reset", s, 8'h05);
    rx_send(8'h2A, 7, 1, 1, 0, 1, 16);
    get_status(s);
    chk(!s[3] && s[1], "R7 good parity", s, 8'h07);
    read_data(d);
  endtask

  task automatic t_framing();
    logic [7:0] s, d;
    set_format(8'h4E); drain();
    rx_send(8'h0F, 8, 0, 0, 0, 0, 16);
    get_status(s);
    chk(s[5] && s[1], "R10 framing error", s, 8'h27);
    read_data(d);
    chk(d == 8'h0F, "R10 data with framing error", d, 8'h0F);
    drain();
  endtask

  task automatic t_overrun();
    logic [7:0] s, d;
    set_format(8'h4E); drain();
    rx_send(8'h11, 8, 0, 0, 0, 1, 16);
    rx_send(8'h22, 8, 0, 0, 0, 1, 16);
    get_status(s);
    chk(s[4] && s[1], "R9 overrun flagged", s, 8'h17);
    read_data(d);
    chk(d == 8'h22, "R9 newest kept", d, 8'h22);
    get_status(s);
    chk(!s[1], "R8 read clears waiting", s, 8'h15);
    ctl_write(8'h37);
  endtask

  task automatic t_collision();
    logic [7:0] s, d, old_d;
    set_format(8'h4E); drain();
    rx_send(8'h33, 8, 0, 0, 0, 1, 16);
    fork
      rx_send(8'h44, 8, 0, 0, 0, 1, 16);
      begin
        @(negedge clk);
        repeat (152) @(posedge clk);
        @(negedge clk); sel_ctl = 1'b0; rd_en = 1'b1; #1 old_d = rdata;
        @(negedge clk); rd_en = 1'b0;
      end
    join
    chk(old_d == 8'h33, "R8 colliding read returns old", old_d, 8'h33);
    get_status(s);
    chk(s[1] && !s[4], "R8 R9 completion wins, no overrun", s, 8'h07);
    read_data(d);
    chk(d == 8'h44, "R8 new char after collision", d, 8'h44);
  endtask

  task automatic t_break();
    logic [7:0] s;
    set_format(8'h4E); drain();
    @(negedge clk); rxd_drv = 1'b0;
    repeat (100) @(negedge clk);
    get_status(s);
    chk(!s[6], "R12 no break before char time", s, 8'h05);
    repeat (100) @(negedge clk);
    get_status(s);
    chk(s[6], "R12 break detected", s, 8'h45);
    rxd_drv = 1'b1;
    repeat (2) @(negedge clk);
    get_status(s);
    chk(!s[6], "R12 break clears on high", s, 8'h05);
    repeat (300) @(negedge clk);
    drain();
  endtask

  task automatic t_rx_disabled();
    logic [7:0] s, d;
    set_format(8'h4E); drain();
    ctl_write(8'h33);
    rx_send(8'h5A, 8, 0, 0, 0, 1, 16);
    get_status(s);
    chk(!s[1], "R13 receiver disabled", s, 8'h05);
    ctl_write(8'h37);
    rx_send(8'h5A, 8, 0, 0, 0, 1, 16);
    read_data(d);
    chk(d == 8'h5A, "R13 receiver re-enabled", d, 8'h5A);
  endtask

  task automatic t_lines();
    logic [7:0] s;
    dsr_n = 1'b0;
    get_status(s);
    chk(s[7], "R5 dsr inverse", s, 8'h85);
    dsr_n = 1'b1;
    ctl_write(8'h3F);
    @(negedge clk);
    chk(!txd, "R4 break send forces low", {7'b0, txd}, 8'h00);
    ctl_write(8'h37);
    @(negedge clk);
    chk(txd, "R4 break send released", {7'b0, txd}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_phase();
    t_tx_8n1();
    t_tx_7e1();
    t_loop(8'hE2, 8'hF3, 8'h13, 260, "R6 R2 five-bit odd two-stop loop");
    t_loop(8'h4D, 8'h5A, 8'h5A, 30, "R2 one tick per bit loop");
    t_loop(8'h4F, 8'hC3, 8'hC3, 800, "R2 sixty-four ticks per bit loop");
    t_loop(8'hAA, 8'h6B, 8'h6B, 260, "R2 seven-bit odd 1.5-stop loop");
    t_glitch();
    t_parity();
    t_framing();
    t_overrun();
    t_collision();
    t_break();
    t_rx_disabled();
    t_lines();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule